// File: doc/BRIEF.md
# Variable-Depth Pixel Shifter

This block sits at the end of a video pipeline. It takes packed (chunky) pixel words from a scanline line-buffer feeder and emits one palette index per dot-clock enable. One shift register serves four pixel depths, 1, 2, 4 or 8 bits per pixel (2, 4, 16 or 256 colours), by moving 1, 2, 4 or 8 bits per dot. All bits of a pixel are adjacent in the word. The pixel that comes first is in the most significant bits.

Each pixel is zero-extended to 8 bits and then XORed with a programmable mask. This lets the low-depth modes address any region of a 256-entry palette. The block pulls words from the feeder with a request/acknowledge pair. It raises the request during the last pixel of the current word, so a feeder that acknowledges in that cycle gives an unbroken pixel stream. While blanking is asserted the output is quiet and the shifter holds its place.

Top module: `pix_unpacker`

## Requirements
- R1: After reset no word is held: `fd_req` is 1, `idx_valid` is 0 and `idx_out` is 0.
- R2: `depth_sel` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel. This gives 16, 8, 4 and 2 pixels per 16-bit word.
- R3: Pixels leave in order from the most significant end of the word. Pixel k of width w is bits [15-k*w -: w].
- R4: When `idx_valid` is 1, `idx_out` equals the zero-extended pixel XOR `xor_mask`. When `idx_valid` is 0, `idx_out` is 0.
- R5: `idx_valid` is 1 exactly when a word is held, `dot_en` is 1 and `blank` is 0. The shifter advances one pixel only in such a cycle and holds its place otherwise.
- R6: While `blank` is 1, `idx_out` is 0, `idx_valid` is 0 and no pixel is consumed.
- R7: `fd_req` is 1 when no word is held, or when the last pixel of the held word is being consumed in this cycle. It is 0 otherwise. A word loads when `fd_req` and `fd_ack` are both 1. An `fd_ack` while `fd_req` is 0 is ignored.
- R8: If the feeder acknowledges during the last pixel, the first pixel of the new word is presented on the next advancing cycle, with no gap.
- R9: `depth_sel` is captured only when a word loads. A change in the middle of a word leaves the remaining pixels of that word at the old depth.
- R10: When the held word is used up and no new word has loaded, `idx_valid` stays 0 even with `dot_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dot_en | input | 1 | Dot-clock enable; one pixel per high cycle |
| blank | input | 1 | Blanking; silences output and holds the shifter |
| depth_sel | input | 2 | Pixel depth code (0:1, 1:2, 2:4, 3:8 bits) |
| xor_mask | input | 8 | Mask XORed into every emitted index |
| fd_data | input | 16 | Packed pixel word from the feeder |
| fd_ack | input | 1 | Feeder acknowledge; `fd_data` is valid |
| fd_req | output | 1 | Request for the next word |
| idx_out | output | 8 | Palette index bus |
| idx_valid | output | 1 | Index on `idx_out` is a live pixel |

## Verification
The hardest case to reach is the handover at a word boundary. The acknowledge must arrive in the very cycle the last pixel is consumed, and a depth change must already be pending. The stimulus first stalls the shifter with `dot_en` low and an ignored acknowledge. It then blanks for one cycle and changes `depth_sel` partway through an 8-bit word. On the final pixel it answers the request at once, so the bench sees in consecutive cycles that the old word kept its depth and the new word started without a gap at the new depth. A table of words, depths and masks then covers every depth, including the exhaustion of each word.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   typedef enum logic [1:0] {
      DEP_1 = 2'd0,
      DEP_2 = 2'd1,
      DEP_4 = 2'd2,
      DEP_8 = 2'd3
   } depth_e;

   localparam int N_DEPTHS = 4;
   localparam int MAX_PIX_W = 1 << (N_DEPTHS - 1);
endpackage

// File: rtl/pxs_word_reg.sv
module pxs_word_reg
   import pxs_pkg::*;
#(
   parameter int WORD_W = 16,
   localparam int CNT_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [WORD_W-1:0] load_word,
   input  depth_e            load_depth,
   output logic [WORD_W-1:0] sr_q,
   output depth_e            depth_q,
   output logic [CNT_W-1:0]  left_q,
   output logic              held_q
);
   logic [WORD_W-1:0] shifted [N_DEPTHS];
   logic [CNT_W-1:0]  per_word [N_DEPTHS];

   for (genvar g = 0; g < N_DEPTHS; g++) begin : g_step
      localparam int STEP = 1 << g;
      assign shifted[g]  = {sr_q[WORD_W-1-STEP:0], {STEP{1'b0}}};
      assign per_word[g] = CNT_W'(WORD_W / STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '0;
         depth_q <= DEP_1;
         left_q  <= '0;
         held_q  <= 1'b0;
      end else if (load) begin
         sr_q    <= load_word;
         depth_q <= load_depth;
         left_q  <= per_word[load_depth];
         held_q  <= 1'b1;
      end else if (advance) begin
         sr_q   <= shifted[depth_q];
         left_q <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) held_q <= 1'b0;
      end
   end

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !load) |=> ($stable(sr_q) && $stable(left_q)));
   p_depth_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(depth_q));
   p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |-> (left_q != '0 && left_q <= CNT_W'(WORD_W)));
endmodule

// File: rtl/pxs_index_out.sv
module pxs_index_out
   import pxs_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int IDX_W  = 8
) (
   input  logic [WORD_W-1:0] sr_q,
   input  depth_e            depth_q,
   input  logic [IDX_W-1:0]  mask,
   input  logic              live,
   output logic [IDX_W-1:0]  idx
);
   logic [IDX_W-1:0] cand [N_DEPTHS];

   for (genvar g = 0; g < N_DEPTHS; g++) begin : g_pick
      localparam int PW = 1 << g;
      if (PW < IDX_W) begin : g_pad
         assign cand[g] = {{(IDX_W-PW){1'b0}}, sr_q[WORD_W-1 -: PW]};
      end else begin : g_full
         assign cand[g] = sr_q[WORD_W-1 -: IDX_W];
      end
   end

   always_comb begin
      idx = '0;
      if (live) idx = cand[depth_q] ^ mask;
   end
endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
   import pxs_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              blank,
   input  logic [1:0]        depth_sel,
   input  logic [IDX_W-1:0]  xor_mask,
   input  logic [WORD_W-1:0] fd_data,
   input  logic              fd_ack,
   output logic              fd_req,
   output logic [IDX_W-1:0]  idx_out,
   output logic              idx_valid
);
   localparam int CNT_W = $clog2(WORD_W + 1);

   if (IDX_W != MAX_PIX_W) begin : g_bad_idx
      $error("IDX_W must equal the widest pixel");
   end
   if (WORD_W % MAX_PIX_W != 0 || WORD_W < 2 * MAX_PIX_W) begin : g_bad_word
      $error("WORD_W must be a multiple of the widest pixel, at least two pixels");
   end

   logic [WORD_W-1:0] sr_q;
   depth_e            depth_q;
   logic [CNT_W-1:0]  left_q;
   logic              held_q;
   logic              advance, last_pix, load;

   assign advance   = held_q && dot_en && !blank;
   assign last_pix  = (left_q == CNT_W'(1));
   assign fd_req    = !held_q || (last_pix && advance);
   assign load      = fd_req && fd_ack;
   assign idx_valid = advance;

   pxs_word_reg #(.WORD_W(WORD_W)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .advance    (advance),
      .load_word  (fd_data),
      .load_depth (depth_e'(depth_sel)),
      .sr_q       (sr_q),
      .depth_q    (depth_q),
      .left_q     (left_q),
      .held_q     (held_q)
   );

   pxs_index_out #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_idx (
      .sr_q    (sr_q),
      .depth_q (depth_q),
      .mask    (xor_mask),
      .live    (advance),
      .idx     (idx_out)
   );

   p_blank_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> (!idx_valid && idx_out == '0));
   p_req_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !held_q |-> fd_req);
   p_valid_needs_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> held_q);
   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_valid |-> (idx_out == '0));
   p_load_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> held_q);
endmodule

// File: tb/sim_pix_unpacker.sv
`timescale 1ns/1ps
module sim_pix_unpacker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dot_en = 1'b0;
   logic        blank = 1'b0;
   logic [1:0]  depth_sel = 2'd0;
   logic [7:0]  xor_mask = 8'd0;
   logic [15:0] fd_data = 16'd0;
   logic        fd_ack = 1'b0;
   logic        fd_req;
   logic [7:0]  idx_out;
   logic        idx_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pix_unpacker u0 (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .blank(blank),
      .depth_sel(depth_sel), .xor_mask(xor_mask), .fd_data(fd_data),
      .fd_ack(fd_ack), .fd_req(fd_req), .idx_out(idx_out), .idx_valid(idx_valid)
   );

   // {depth code, word, mask}
   localparam logic [25:0] VECS [6] = '{
      {2'd0, 16'h8001, 8'hA4},
      {2'd0, 16'h5A3C, 8'h00},
      {2'd1, 16'hE41B, 8'h30},
      {2'd2, 16'h1F7C, 8'h90},
      {2'd3, 16'hC35A, 8'hFF},
      {2'd3, 16'h0180, 8'h00}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ref_pix(input logic [15:0] w, input int d, input int k,
                                  input logic [7:0] m);
      int pw = 1 << d;
      return (((int'(w) >> (16 - (k + 1) * pw)) & ((1 << pw) - 1)) ^ int'(m));
   endfunction

   task automatic run_word(input int d, input logic [15:0] w, input logic [7:0] m);
      int n = 16 >> d;
      @(negedge clk);
      dot_en = 1'b0; blank = 1'b0; depth_sel = 2'(d); fd_data = w; fd_ack = 1'b1; xor_mask = m;
      #1 check(fd_req == 1'b1, "R7 req when empty", fd_req, 1);
      @(negedge clk);
      fd_ack = 1'b0; fd_data = 16'h0;
      for (int k = 0; k < n; k++) begin
         dot_en = 1'b1;
         #1;
         check(idx_valid == 1'b1, "R5 valid while shifting", idx_valid, 1);
         check(int'(idx_out) == ref_pix(w, d, k, m), "R2 R3 R4 pixel value",
               idx_out, ref_pix(w, d, k, m));
         check(fd_req == (k == n - 1), "R7 req only on last pixel", fd_req, (k == n - 1));
         @(negedge clk);
      end
      dot_en = 1'b1;
      #1;
      check(idx_valid == 1'b0 && idx_out == 8'h0, "R10 exhausted word", idx_valid, 0);
      dot_en = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      dot_en = 1'b1;
      #1 check(fd_req == 1'b1 && idx_valid == 1'b0 && idx_out == 8'h0,
               "R1 state in reset", {fd_req, idx_valid, idx_out}, 10'h200);
      @(negedge clk);
      rst_n = 1'b1;
      #1 check(fd_req == 1'b1 && idx_valid == 1'b0 && idx_out == 8'h0,
               "R1 state after reset", {fd_req, idx_valid, idx_out}, 10'h200);
      dot_en = 1'b0;

      // Stall, ignored ack, blanking, mid-word depth change, gapless handover
      @(negedge clk);
      depth_sel = 2'd3; fd_data = 16'hF00F; fd_ack = 1'b1; xor_mask = 8'h00;
      @(negedge clk);
      dot_en = 1'b0; fd_data = 16'h1234; fd_ack = 1'b1;
      #1 check(fd_req == 1'b0, "R7 no req mid-word", fd_req, 0);
      check(idx_valid == 1'b0, "R5 no valid without dot_en", idx_valid, 0);
      @(negedge clk);
      fd_ack = 1'b0; dot_en = 1'b1; blank = 1'b1;
      #1 check(idx_out == 8'h0 && idx_valid == 1'b0, "R6 blank quiets output",
               idx_out, 0);
      @(negedge clk);
      blank = 1'b0;
      #1 check(idx_out == 8'hF0 && idx_valid, "R5 R6 R7 held first pixel", idx_out, 8'hF0);
      depth_sel = 2'd0;
      @(negedge clk);
      fd_data = 16'hABCD; fd_ack = 1'b1; depth_sel = 2'd2;
      #1 check(idx_out == 8'h0F, "R9 old depth kept mid-word", idx_out, 8'h0F);
      check(fd_req == 1'b1, "R7 req on last pixel", fd_req, 1);
      @(negedge clk);
      fd_ack = 1'b0; depth_sel = 2'd0;
      #1 check(idx_out == 8'h0A && idx_valid, "R8 gapless new word", idx_out, 8'h0A);
      @(negedge clk);
      #1 check(idx_out == 8'h0B, "R9 new depth latched at load", idx_out, 8'h0B);
      @(negedge clk);
      #1 check(idx_out == 8'h0C, "R3 third nibble", idx_out, 8'h0C);
      @(negedge clk);
      #1 check(idx_out == 8'h0D, "R3 fourth nibble", idx_out, 8'h0D);
      @(negedge clk);
      #1 check(idx_valid == 1'b0 && fd_req == 1'b1, "R10 underrun", idx_valid, 0);
      dot_en = 1'b0;

      for (int i = 0; i < 6; i++) begin
         run_word(int'(VECS[i][25:24]), VECS[i][23:8], VECS[i][7:0]);
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule